// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the four status flags of a UART-style serial port and produces its single interrupt request. The transmit and receive datapaths send it event strobes: the transmit buffer has been loaded into the shifter, the shifter is busy, a received character has moved into the receive buffer, and each sampled receive-line bit. It also sees CPU reads of the status register, reads and writes of the data register, and four interrupt enables.

Each flag is a small state machine with three states. `FLAG_LOW` means the flag reads 0. `FLAG_HIGH` means it reads 1 and is not armed. `FLAG_ARMED` means it reads 1 and a status read has already seen it. The transitions are:

- set: `FLAG_LOW` to `FLAG_HIGH`.
- arm: `FLAG_HIGH` to `FLAG_ARMED`, on a status read with no data access in the same cycle.
- clear: `FLAG_ARMED` to `FLAG_LOW`, on the matching data access when no set event occurs in that cycle.
- disarm: `FLAG_ARMED` to `FLAG_HIGH`, on any other data access, or on the clearing access when it coincides with a set.

A separate counter watches the receive line for a run of ones to detect an idle line.

Top module: `sci_flag_ctrl`

## Requirements
- R1: After reset, `txe_o`=1, `tc_o`=1, `rxf_o`=0, `idle_o`=0 and `irq_o`=0.
- R2: `tx_load_i` high in a cycle makes `txe_o` 1 after that clock edge.
- R3: `tc_o` becomes 1 after any edge at which `txe_o` was 1, `tx_busy_i` was 0 and `data_wr_i` was 0.
- R4: `rx_load_i` high in a cycle makes `rxf_o` 1 after that clock edge.
- R5: `idle_o` becomes 1 at the edge that takes in the 10th consecutive sampled one when `long_frame_i`=0, or the 11th when `long_frame_i`=1. A sampled zero restarts the count, and the count saturates at 11. After idle has been cleared, it cannot set again until a zero has been sampled.
- R6: A status read (`stat_rd_i`) with no data access in the same cycle arms every flag that reads 1. Any data access (`data_rd_i` or `data_wr_i`) disarms all flags.
- R7: An armed `txe_o`/`tc_o` clears on `data_wr_i`. An armed `rxf_o`/`idle_o` clears on `data_rd_i`. A data access to a flag that is not armed leaves the flag unchanged.
- R8: A set event in the same cycle as a completing clear leaves the flag at 1.
- R9: `irq_o` is a register loaded each edge with the OR of the flags ANDed with `irq_en_i`, where bit 0 is txe, bit 1 is tc, bit 2 is rxf and bit 3 is idle. It therefore follows the flags one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_load_i | input | 1 | Transmit buffer loaded into the shifter |
| tx_busy_i | input | 1 | Shifter sending data, preamble or break |
| rx_load_i | input | 1 | Received character moved into the buffer |
| rx_smp_vld_i | input | 1 | Receive-line bit sample strobe |
| rx_smp_bit_i | input | 1 | Sampled receive-line value |
| long_frame_i | input | 1 | 1 selects 9-bit frames (idle after 11 ones) |
| stat_rd_i | input | 1 | CPU status register read |
| data_rd_i | input | 1 | CPU data register read |
| data_wr_i | input | 1 | CPU data register write |
| irq_en_i | input | 4 | Interrupt enables {idle, rxf, tc, txe} |
| txe_o | output | 1 | Transmit buffer empty |
| tc_o | output | 1 | Transmission complete |
| rxf_o | output | 1 | Receive buffer full |
| idle_o | output | 1 | Receive line idle |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The wrong internal state that matters most is an arm bit that is stale or missing. A stale arm shows up as a flag that drops on an ordinary data access without a prior status read. A missing arm shows up as a flag that stays at 1 after a full status-then-data sequence. Either appears at the flag output at the edge that ends the sequence. A wrong idle count shows at `idle_o` one sample too early or too late. Any wrong flag reaches `irq_o` exactly one cycle after it appears on its own output, so the bench compares all five outputs against a reference model on every cycle.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;
    typedef enum logic [1:0] {
        FLAG_LOW   = 2'd0,
        FLAG_HIGH  = 2'd1,
        FLAG_ARMED = 2'd2
    } flag_state_e;

    localparam int NUM_FLAGS = 4;
    localparam int F_TXE  = 0;
    localparam int F_TC   = 1;
    localparam int F_RXF  = 2;
    localparam int F_IDLE = 3;
endpackage

// File: rtl/sci_flag_fsm.sv
module sci_flag_fsm
    import sci_flag_pkg::*;
#(
    parameter bit RESET_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic clr_acc_i,
    input  logic any_acc_i,
    output logic flag_o
);
    localparam flag_state_e RST_STATE = RESET_SET ? FLAG_HIGH : FLAG_LOW;

    flag_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW: begin
                if (set_i) state_d = FLAG_HIGH;
            end
            FLAG_HIGH: begin
                if (stat_rd_i && !any_acc_i) state_d = FLAG_ARMED;
            end
            FLAG_ARMED: begin
                if (any_acc_i)
                    state_d = (clr_acc_i && !set_i) ? FLAG_LOW : FLAG_HIGH;
            end
            default: state_d = RST_STATE;
        endcase
    end

    // outputs
    always_comb begin
        flag_o = (state_q != FLAG_LOW);
    end
endmodule

// File: rtl/sci_idle_detect.sv
module sci_idle_detect #(
    parameter int SHORT_RUN = 10,
    parameter int LONG_RUN  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld_i,
    input  logic smp_bit_i,
    input  logic long_frame_i,
    output logic idle_set_o
);
    localparam int CW = $clog2(LONG_RUN + 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_RUN - 1);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_RUN - 1);
    localparam logic [CW-1:0] SAT      = CW'(LONG_RUN);

    logic [CW-1:0] ones_q;
    logic [CW-1:0] thr_m1;

    always_comb begin
        thr_m1     = long_frame_i ? LONG_M1 : SHORT_M1;
        idle_set_o = smp_vld_i && smp_bit_i && (ones_q == thr_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (smp_vld_i) begin
            if (!smp_bit_i)      ones_q <= '0;
            else if (ones_q != SAT) ones_q <= ones_q + 1'b1;
        end
    end
endmodule

// File: rtl/sci_irq_merge.sv
module sci_irq_merge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags_i & en_i);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/sci_flag_ctrl.sv
module sci_flag_ctrl
    import sci_flag_pkg::*;
#(
    parameter int SHORT_RUN = 10,
    parameter int LONG_RUN  = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_load_i,
    input  logic                 tx_busy_i,
    input  logic                 rx_load_i,
    input  logic                 rx_smp_vld_i,
    input  logic                 rx_smp_bit_i,
    input  logic                 long_frame_i,
    input  logic                 stat_rd_i,
    input  logic                 data_rd_i,
    input  logic                 data_wr_i,
    input  logic [NUM_FLAGS-1:0] irq_en_i,
    output logic                 txe_o,
    output logic                 tc_o,
    output logic                 rxf_o,
    output logic                 idle_o,
    output logic                 irq_o
);
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    logic                 idle_set;
    logic                 any_acc;

    sci_idle_detect #(
        .SHORT_RUN(SHORT_RUN),
        .LONG_RUN (LONG_RUN)
    ) idle_det_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld_i   (rx_smp_vld_i),
        .smp_bit_i   (rx_smp_bit_i),
        .long_frame_i(long_frame_i),
        .idle_set_o  (idle_set)
    );

    always_comb begin
        any_acc          = data_rd_i | data_wr_i;
        flag_set[F_TXE]  = tx_load_i;
        flag_set[F_TC]   = flag_q[F_TXE] & ~tx_busy_i & ~data_wr_i;
        flag_set[F_RXF]  = rx_load_i;
        flag_set[F_IDLE] = idle_set;
        flag_clr[F_TXE]  = data_wr_i;
        flag_clr[F_TC]   = data_wr_i;
        flag_clr[F_RXF]  = data_rd_i;
        flag_clr[F_IDLE] = data_rd_i;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam bit RS = (i == F_TXE) || (i == F_TC);
        sci_flag_fsm #(.RESET_SET(RS)) fsm_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (flag_set[i]),
            .stat_rd_i(stat_rd_i),
            .clr_acc_i(flag_clr[i]),
            .any_acc_i(any_acc),
            .flag_o   (flag_q[i])
        );
    end

    sci_irq_merge #(.N(NUM_FLAGS)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags_i(flag_q),
        .en_i   (irq_en_i),
        .irq_o  (irq_o)
    );

    assign txe_o  = flag_q[F_TXE];
    assign tc_o   = flag_q[F_TC];
    assign rxf_o  = flag_q[F_RXF];
    assign idle_o = flag_q[F_IDLE];
endmodule

// File: rtl/sci_flag_ctrl_chk.sv
module sci_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_load_i,
    input logic       tx_busy_i,
    input logic       rx_load_i,
    input logic       rx_smp_vld_i,
    input logic       rx_smp_bit_i,
    input logic       data_rd_i,
    input logic       data_wr_i,
    input logic [3:0] irq_en_i,
    input logic       txe_o,
    input logic       tc_o,
    input logic       rxf_o,
    input logic       idle_o,
    input logic       irq_o
);
    // R2
    txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> txe_o);
    // R4
    rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load_i |=> rxf_o);
    // R3
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txe_o && !tx_busy_i && !data_wr_i) |=> tc_o);
    // R7
    txe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txe_o) |-> $past(data_wr_i));
    // R7
    rxf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxf_o) |-> $past(data_rd_i));
    // R7
    idle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_o) |-> $past(data_rd_i));
    // R5
    idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(rx_smp_vld_i && rx_smp_bit_i));
    // R8
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load_i && data_rd_i) |=> rxf_o);
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|({idle_o, rxf_o, tc_o, txe_o} & irq_en_i)) |=> !irq_o);
    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_o && irq_en_i[2]) |=> irq_o);
endmodule

bind sci_flag_ctrl sci_flag_ctrl_chk chk_i (.*);

// File: tb/sci_flag_ctrl_tb_top.sv
module sci_flag_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_load = 0, tx_busy = 0, rx_load = 0, smp_vld = 0, smp_bit = 0;
    logic long_frame = 0, stat_rd = 0, data_rd = 0, data_wr = 0;
    logic [3:0] irq_en = 4'b0;
    logic txe, tc, rxf, idle, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_flag [4];
    bit m_arm  [4];
    int m_cnt;
    bit m_irq;

    always #4 clk = ~clk;

    sci_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tx_load_i(tx_load), .tx_busy_i(tx_busy),
        .rx_load_i(rx_load), .rx_smp_vld_i(smp_vld), .rx_smp_bit_i(smp_bit),
        .long_frame_i(long_frame), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
        .data_wr_i(data_wr), .irq_en_i(irq_en), .txe_o(txe), .tc_o(tc),
        .rxf_o(rxf), .idle_o(idle), .irq_o(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit idle_fires(input int cnt, input bit lng, input bit v, input bit b);
        return v && b && (cnt == (lng ? 10 : 9));
    endfunction

    function automatic bit flag_next(input bit f, input bit a, input bit set, input bit clr);
        return set || (f && !(a && clr));
    endfunction

    function automatic bit arm_next(input bit f, input bit a, input bit rd, input bit acc);
        return acc ? 1'b0 : ((rd && f) ? 1'b1 : a);
    endfunction

    task automatic model_reset();
        m_flag[0] = 1; m_flag[1] = 1; m_flag[2] = 0; m_flag[3] = 0;
        for (int i = 0; i < 4; i++) m_arm[i] = 0;
        m_cnt = 0; m_irq = 0;
    endtask

    task automatic model_step();
        bit set [4];
        bit clr [4];
        bit acc;
        bit nf [4];
        acc = data_rd || data_wr;
        set[0] = tx_load;
        set[1] = m_flag[0] && !tx_busy && !data_wr;
        set[2] = rx_load;
        set[3] = idle_fires(m_cnt, long_frame, smp_vld, smp_bit);
        clr[0] = data_wr; clr[1] = data_wr; clr[2] = data_rd; clr[3] = data_rd;
        m_irq = (m_flag[0] && irq_en[0]) || (m_flag[1] && irq_en[1]) ||
                (m_flag[2] && irq_en[2]) || (m_flag[3] && irq_en[3]);
        for (int i = 0; i < 4; i++) begin
            nf[i] = flag_next(m_flag[i], m_arm[i], set[i], clr[i]);
            m_arm[i] = arm_next(m_flag[i], m_arm[i], stat_rd, acc);
        end
        for (int i = 0; i < 4; i++) m_flag[i] = nf[i];
        if (smp_vld) begin
            if (!smp_bit) m_cnt = 0;
            else if (m_cnt < 11) m_cnt++;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        check("R2 txe", txe, m_flag[0]);
        check("R3 tc", tc, m_flag[1]);
        check("R4 rxf", rxf, m_flag[2]);
        check("R5 idle", idle, m_flag[3]);
        check("R9 irq", irq, m_irq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5C1F_1A65));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        check("R1 txe", txe, 1'b1);
        check("R1 tc", tc, 1'b1);
        check("R1 rxf", rxf, 1'b0);
        check("R1 idle", idle, 1'b0);
        check("R1 irq", irq, 1'b0);

        // R7 unarmed write has no effect
        data_wr = 1; tick(); data_wr = 0;
        check("R7 unarmed txe", txe, 1'b1);
        // R6 arm then clear
        tx_busy = 1; stat_rd = 1; tick(); stat_rd = 0;
        data_wr = 1; tick(); data_wr = 0;
        check("R6 txe cleared", txe, 1'b0);
        check("R6 tc cleared", tc, 1'b0);
        tick();
        tx_load = 1; tick(); tx_load = 0;
        check("R2 txe set", txe, 1'b1);
        tick();
        check("R3 tc held while busy", tc, 1'b0);
        tx_busy = 0; tick();
        check("R3 tc set", tc, 1'b1);

        // R5 idle with 8-bit frames
        smp_vld = 1; smp_bit = 1; long_frame = 0;
        repeat (9) tick();
        check("R5 nine ones", idle, 1'b0);
        tick();
        check("R5 ten ones", idle, 1'b1);
        smp_vld = 0; stat_rd = 1; tick(); stat_rd = 0;
        data_rd = 1; tick(); data_rd = 0;
        check("R7 idle cleared", idle, 1'b0);
        smp_vld = 1; repeat (12) tick();
        check("R5 no reset without zero", idle, 1'b0);
        smp_bit = 0; tick(); smp_bit = 1; long_frame = 1;
        repeat (10) tick();
        check("R5 ten ones long", idle, 1'b0);
        tick();
        check("R5 eleven ones long", idle, 1'b1);
        smp_vld = 0;

        // R8 set wins
        rx_load = 1; tick(); rx_load = 0;
        check("R4 rxf set", rxf, 1'b1);
        stat_rd = 1; tick(); stat_rd = 0;
        data_rd = 1; rx_load = 1; tick(); data_rd = 0; rx_load = 0;
        check("R8 rxf kept", rxf, 1'b1);
        data_rd = 1; tick(); data_rd = 0;
        check("R6 disarmed by access", rxf, 1'b1);

        // R9 interrupt one cycle later
        irq_en = 4'b0100; tick();
        check("R9 irq raised", irq, 1'b1);
        irq_en = 4'b0000; tick();
        check("R9 irq dropped", irq, 1'b0);

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            tx_load = ($urandom % 8) == 0;
            tx_busy = ($urandom % 2) == 0;
            rx_load = ($urandom % 8) == 0;
            smp_vld = ($urandom % 2) == 0;
            smp_bit = ($urandom % 16) != 0;
            stat_rd = ($urandom % 4) == 0;
            data_rd = ($urandom % 8) == 0;
            data_wr = ($urandom % 8) == 0;
            if (($urandom % 64) == 0) long_frame = ~long_frame;
            if (($urandom % 16) == 0) irq_en = 4'($urandom);
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule